// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block moves a small processor core between normal operation and two low-power states: a light one, where only the CPU clock is gated, and a deep one, where the oscillator is also stopped. Single-cycle strobes from the core's instruction decoder start each state. The block then watches the interrupt sources and a reset request. When a release condition arrives, it reopens the clocks in the right order. It then issues a one-cycle wake strobe and a code that tells the core how to resume.

The release decision combines, for each interrupt source, its request, mask and priority bits with the global interrupt enable and the in-service-priority flag. The deep state may only be entered while the core runs from the main system clock. If an unmasked request is already pending when the deep-state strobe arrives, the block skips the deep state. It keeps the oscillator running with the CPU clock gated, waits the programmed stabilization count, and then wakes.

Top module: `standby_wake_ctrl`

## Requirements
- R1: A deep-standby strobe while `main_clk_sel` is 0 is ignored. The core keeps running with both clocks enabled and no wake strobe.
- R2: In light standby, `cpu_clk_en` is 0 and `osc_en` is 1. In deep standby, both are 0. In normal operation, both are 1.
- R3: A source whose mask bit is 1 never releases light standby, whatever its priority bit, `glob_ie` or `isp_flag`.
- R4: An unmasked source with priority bit 0 releases standby. The resume code is 01 (next instruction) when `glob_ie` is 0 and 10 (interrupt servicing) when `glob_ie` is 1.
- R5: An unmasked source with priority bit 1 releases standby. The resume code is 10 only when `glob_ie` and `isp_flag` are both 1; otherwise it is 01.
- R6: `sys_reset_req` releases either standby state, or an ongoing stabilization wait, on the next clock with resume code 11. This overrides any interrupt decision. In normal operation it has no effect.
- R7: If an unmasked request is pending when a light-standby strobe arrives, light standby lasts exactly one cycle. The wake strobe appears two cycles after the strobe was sampled.
- R8: If an unmasked request is pending when an allowed deep-standby strobe arrives, the oscillator stays on and the CPU clock is gated. The wake strobe appears `osc_wait`+2 cycles after the strobe was sampled.
- R9: When an interrupt releases deep standby, `osc_en` rises on the next clock while `cpu_clk_en` stays 0. The wake strobe follows `osc_wait`+1 cycles after that.
- R10: `wake` is a one-cycle pulse. `resume_code` is 00 whenever `wake` is 0, and is 01, 10 or 11 in the wake cycle. `cpu_clk_en` is 1 in the wake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| halt_exec | input | 1 | Light-standby instruction strobe |
| stop_exec | input | 1 | Deep-standby instruction strobe |
| main_clk_sel | input | 1 | 1 when the core runs from the main system clock |
| irq_req | input | NUM_SRC | Per-source interrupt request flags |
| irq_mask | input | NUM_SRC | Per-source mask bits, 1 = masked |
| irq_prio | input | NUM_SRC | Per-source priority bits, 0 = high |
| glob_ie | input | 1 | Global interrupt enable |
| isp_flag | input | 1 | In-service-priority flag |
| osc_wait | input | CNT_W | Oscillation stabilization count |
| sys_reset_req | input | 1 | Reset request acting as an unconditional release |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| wake | output | 1 | One-cycle wake strobe |
| resume_code | output | 2 | 00 none, 01 next instruction, 10 interrupt servicing, 11 reset processing |

## Verification
The embedded properties check several rules on every cycle:
- the wake strobe never lasts longer than one cycle;
- light standby with no unmasked request is held;
- a reset request always produces code 11;
- a deep-standby strobe without the main clock leaves the core running;
- the stabilization counter steps down by exactly one and never wakes early.

Only the bench scenarios can show the exact resume codes across the `glob_ie`/`isp_flag`/priority combinations, the precise wake cycle counted from a strobe or release for several `osc_wait` values, and the order in which the oscillator and CPU clock come back.

// File: rtl/standby_pkg.sv
package standby_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'b00,
      ST_HALT   = 2'b01,
      ST_STOP   = 2'b10,
      ST_SETTLE = 2'b11
   } sb_state_t;

   typedef enum logic [1:0] {
      RES_NONE    = 2'b00,
      RES_NEXT    = 2'b01,
      RES_SERVICE = 2'b10,
      RES_RESET   = 2'b11
   } resume_t;

endpackage

// File: rtl/wake_eval.sv
module wake_eval
   import standby_pkg::*;
#(
   parameter int NUM_SRC = 8
) (
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic [NUM_SRC-1:0] prio_i,
   input  logic               glob_ie_i,
   input  logic               isp_i,
   output logic               any_pend_o,
   output resume_t            action_o
);

   localparam int LAST = NUM_SRC - 1;

   logic [LAST:0] hi_pend;
   logic [LAST:0] lo_pend;
   logic [LAST:0] svc_ok;

   // per-source classification: unmasked high or low priority request
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hi_pend[i] = req_i[i] & ~mask_i[i] & ~prio_i[i];
      assign lo_pend[i] = req_i[i] & ~mask_i[i] &  prio_i[i];
      assign svc_ok[i]  = glob_ie_i & (hi_pend[i] | (lo_pend[i] & isp_i));
   end

   assign any_pend_o = |(hi_pend | lo_pend);

   always_comb begin
      if (|svc_ok) action_o = RES_SERVICE;
      else         action_o = RES_NEXT;
   end

endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             zero_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_q <= CNT_ZERO;
      else if (load_i)                      cnt_q <= load_val_i;
      else if (dec_i && cnt_q != CNT_ZERO)  cnt_q <= cnt_q - CNT_ONE;
   end

   assign zero_o = (cnt_q == CNT_ZERO);

   // each waiting cycle removes exactly one count (R9)
   assert_settle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

   // the count never wraps below zero (R8)
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
   import standby_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      halt_exec_i,
   input  logic      stop_exec_i,
   input  logic      main_clk_i,
   input  logic      reset_req_i,
   input  logic      any_pend_i,
   input  resume_t   action_i,
   input  logic      cnt_zero_i,
   output sb_state_t state_o,
   output logic      cnt_load_o,
   output logic      cnt_dec_o,
   output logic      wake_o,
   output resume_t   code_o
);

   sb_state_t state_q, state_n;
   resume_t   held_q, held_n;
   resume_t   code_n;
   logic      wake_n;

   always_comb begin
      state_n    = state_q;
      held_n     = held_q;
      code_n     = RES_NONE;
      wake_n     = 1'b0;
      cnt_load_o = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (stop_exec_i && main_clk_i) begin
               if (any_pend_i) begin
                  // immediate cancel: fall back to light standby plus settle
                  state_n    = ST_SETTLE;
                  cnt_load_o = 1'b1;
                  held_n     = action_i;
               end else begin
                  state_n = ST_STOP;
               end
            end else if (halt_exec_i) begin
               state_n = ST_HALT;
            end
         end
         ST_HALT: begin
            if (reset_req_i) begin
               state_n = ST_RUN;
               wake_n  = 1'b1;
               code_n  = RES_RESET;
            end else if (any_pend_i) begin
               state_n = ST_RUN;
               wake_n  = 1'b1;
               code_n  = action_i;
            end
         end
         ST_STOP: begin
            if (reset_req_i) begin
               state_n = ST_RUN;
               wake_n  = 1'b1;
               code_n  = RES_RESET;
            end else if (any_pend_i) begin
               state_n    = ST_SETTLE;
               cnt_load_o = 1'b1;
               held_n     = action_i;
            end
         end
         ST_SETTLE: begin
            if (reset_req_i) begin
               state_n = ST_RUN;
               wake_n  = 1'b1;
               code_n  = RES_RESET;
            end else if (cnt_zero_i) begin
               state_n = ST_RUN;
               wake_n  = 1'b1;
               code_n  = held_q;
            end
         end
         default: state_n = ST_RUN;
      endcase
   end

   assign cnt_dec_o = (state_q == ST_SETTLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         held_q  <= RES_NONE;
         wake_o  <= 1'b0;
         code_o  <= RES_NONE;
      end else begin
         state_q <= state_n;
         held_q  <= held_n;
         wake_o  <= wake_n;
         code_o  <= code_n;
      end
   end

   assign state_o = state_q;

   assert_wake_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);

   assert_reset_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_RUN && reset_req_i) |=> (wake_o && code_o == RES_RESET));

   assert_stop_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && stop_exec_i && !main_clk_i && !halt_exec_i)
      |=> (state_q == ST_RUN && !wake_o));

   assert_no_early_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE && !reset_req_i && !cnt_zero_i)
      |=> (!wake_o && state_q == ST_SETTLE));

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
   import standby_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt_exec,
   input  logic               stop_exec,
   input  logic               main_clk_sel,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] irq_mask,
   input  logic [NUM_SRC-1:0] irq_prio,
   input  logic               glob_ie,
   input  logic               isp_flag,
   input  logic [CNT_W-1:0]   osc_wait,
   input  logic               sys_reset_req,
   output logic               cpu_clk_en,
   output logic               osc_en,
   output logic               wake,
   output logic [1:0]         resume_code
);

   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_src
      $error("standby_wake_ctrl: NUM_SRC must lie in 1..64");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("standby_wake_ctrl: CNT_W must lie in 1..32");
   end

   localparam logic [NUM_SRC-1:0] NO_SRC = '0;

   logic      any_pend;
   resume_t   action;
   logic      cnt_load;
   logic      cnt_dec;
   logic      cnt_zero;
   sb_state_t state;
   resume_t   code;

   wake_eval #(.NUM_SRC(NUM_SRC)) u_eval (
      .req_i      (irq_req),
      .mask_i     (irq_mask),
      .prio_i     (irq_prio),
      .glob_ie_i  (glob_ie),
      .isp_i      (isp_flag),
      .any_pend_o (any_pend),
      .action_o   (action)
   );

   settle_counter #(.CNT_W(CNT_W)) u_settle (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_load),
      .load_val_i (osc_wait),
      .dec_i      (cnt_dec),
      .zero_o     (cnt_zero)
   );

   standby_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_exec_i (halt_exec),
      .stop_exec_i (stop_exec),
      .main_clk_i  (main_clk_sel),
      .reset_req_i (sys_reset_req),
      .any_pend_i  (any_pend),
      .action_i    (action),
      .cnt_zero_i  (cnt_zero),
      .state_o     (state),
      .cnt_load_o  (cnt_load),
      .cnt_dec_o   (cnt_dec),
      .wake_o      (wake),
      .code_o      (code)
   );

   assign cpu_clk_en  = (state == ST_RUN);
   assign osc_en      = (state != ST_STOP);
   assign resume_code = code;

   // masked or absent requests keep the core halted (R3)
   assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT && !sys_reset_req && ((irq_req & ~irq_mask) == NO_SRC))
      |=> (state == ST_HALT && !wake));

   // entering light standby gates only the CPU clock (R2)
   assert_halt_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && halt_exec && !stop_exec) |=> (!cpu_clk_en && osc_en));

endmodule

// File: tb/standby_wake_ctrl_test.sv
module standby_wake_ctrl_test;

   localparam int NS = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          halt_exec = 1'b0, stop_exec = 1'b0, main_clk_sel = 1'b1;
   logic [NS-1:0] irq_req = '0, irq_mask = '1, irq_prio = '0;
   logic          glob_ie = 1'b0, isp_flag = 1'b0, sys_reset_req = 1'b0;
   logic [CW-1:0] osc_wait = 16'd5;
   logic          cpu_clk_en, osc_en, wake;
   logic [1:0]    resume_code;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit prev_wake = 1'b0;

   int         exp_cyc[$];
   logic [1:0] exp_code[$];
   string      exp_tag[$];

   standby_wake_ctrl #(.NUM_SRC(NS), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .stop_exec(stop_exec),
      .main_clk_sel(main_clk_sel), .irq_req(irq_req), .irq_mask(irq_mask),
      .irq_prio(irq_prio), .glob_ie(glob_ie), .isp_flag(isp_flag),
      .osc_wait(osc_wait), .sys_reset_req(sys_reset_req),
      .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .wake(wake),
      .resume_code(resume_code)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic push(input int at, input logic [1:0] code, input string tag);
      exp_cyc.push_back(at);
      exp_code.push_back(code);
      exp_tag.push_back(tag);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_halt();
      halt_exec = 1'b1;
      @(negedge clk);
      halt_exec = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_exec = 1'b1;
      @(negedge clk);
      stop_exec = 1'b0;
   endtask

   task automatic clear_irq();
      irq_req = '0; irq_mask = '1; irq_prio = '0;
   endtask

   // monitor: pops the scoreboard whenever a wake strobe appears
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (wake) begin
            if (exp_cyc.size() == 0) begin
               chk("R10 unexpected wake", 1, 0);
            end else begin
               chk({exp_tag[0], " wake cycle"}, cyc, exp_cyc[0]);
               chk({exp_tag[0], " resume code"}, int'(resume_code), int'(exp_code[0]));
               chk("R10 clock on in wake cycle", int'(cpu_clk_en), 1);
               void'(exp_cyc.pop_front());
               void'(exp_code.pop_front());
               void'(exp_tag.pop_front());
            end
            if (prev_wake) chk("R10 wake longer than one cycle", 1, 0);
         end else begin
            if (resume_code != 2'b00) chk("R10 code without wake", int'(resume_code), 0);
            if (exp_cyc.size() > 0 && cyc > exp_cyc[0]) begin
               chk({exp_tag[0], " missing wake"}, cyc, exp_cyc[0]);
               void'(exp_cyc.pop_front());
               void'(exp_code.pop_front());
               void'(exp_tag.pop_front());
            end
         end
         prev_wake = wake;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int k;
      step(3);
      rst_n = 1'b1;
      step(1);
      // reset state
      chk("R2 reset cpu clock", int'(cpu_clk_en), 1);
      chk("R2 reset oscillator", int'(osc_en), 1);
      chk("R10 reset wake", int'(wake), 0);
      chk("R10 reset code", int'(resume_code), 0);

      // R3 then R4: masked requests hold, unmasked high priority releases with 01
      irq_req = 8'h03; irq_prio = 8'h02; irq_mask = 8'hFF;
      glob_ie = 1'b1; isp_flag = 1'b1;
      pulse_halt();
      chk("R2 halt cpu clock", int'(cpu_clk_en), 0);
      chk("R2 halt oscillator", int'(osc_en), 1);
      step(4);
      chk("R3 masked sources keep halt", int'(cpu_clk_en), 0);
      glob_ie = 1'b0;
      irq_mask = 8'hFE;
      push(cyc + 1, 2'b01, "R4 ie=0");
      step(3); clear_irq();

      // R4 with global enable: servicing
      glob_ie = 1'b1; isp_flag = 1'b0;
      pulse_halt(); step(2);
      irq_req = 8'h10; irq_mask = 8'hEF;
      push(cyc + 1, 2'b10, "R4 ie=1");
      step(3); clear_irq();

      // R5 low priority under every enable / in-service combination
      for (int c = 0; c < 4; c++) begin
         glob_ie = c[1]; isp_flag = c[0];
         pulse_halt(); step(1);
         irq_req = 8'h04; irq_prio = 8'h04; irq_mask = 8'hFB;
         push(cyc + 1, (c == 3) ? 2'b10 : 2'b01, "R5 low priority");
         step(3); clear_irq();
      end

      // R7: request already pending at the light-standby strobe
      glob_ie = 1'b0; irq_req = 8'h01; irq_mask = 8'hFE;
      k = cyc;
      push(k + 2, 2'b01, "R7 immediate halt release");
      pulse_halt();
      chk("R7 halted for one cycle", int'(cpu_clk_en), 0);
      step(3); clear_irq();

      // R1: deep standby refused off the main clock
      main_clk_sel = 1'b0;
      pulse_stop();
      chk("R1 cpu clock kept", int'(cpu_clk_en), 1);
      chk("R1 oscillator kept", int'(osc_en), 1);
      step(3);
      chk("R1 still running", int'(cpu_clk_en), 1);
      main_clk_sel = 1'b1;

      // R2, R9: deep standby released by an interrupt after the settle count
      osc_wait = 16'd5; glob_ie = 1'b1;
      pulse_stop();
      chk("R2 stop cpu clock", int'(cpu_clk_en), 0);
      chk("R2 stop oscillator", int'(osc_en), 0);
      step(3);
      chk("R2 stop oscillator held", int'(osc_en), 0);
      irq_req = 8'h01; irq_mask = 8'hFE;
      k = cyc;
      push(k + 7, 2'b10, "R9 stop release");
      step(1);
      chk("R9 oscillator first", int'(osc_en), 1);
      chk("R9 cpu clock still gated", int'(cpu_clk_en), 0);
      step(5);
      chk("R9 gated until wait ends", int'(cpu_clk_en), 0);
      step(3); clear_irq();

      // R8: pending request at the deep-standby strobe
      glob_ie = 1'b0; osc_wait = 16'd3;
      irq_req = 8'h20; irq_prio = 8'h20; irq_mask = 8'hDF;
      k = cyc;
      push(k + 5, 2'b01, "R8 immediate stop cancel");
      pulse_stop();
      chk("R8 oscillator on", int'(osc_en), 1);
      chk("R8 cpu clock gated", int'(cpu_clk_en), 0);
      step(6); clear_irq();

      // R8 with a zero stabilization count
      osc_wait = 16'd0; irq_req = 8'h01; irq_mask = 8'hFE;
      k = cyc;
      push(k + 2, 2'b01, "R8 zero wait");
      pulse_stop();
      step(3); clear_irq();

      // R6: reset request beats a simultaneous interrupt in light standby
      glob_ie = 1'b1;
      pulse_halt(); step(1);
      irq_req = 8'h01; irq_mask = 8'hFE; sys_reset_req = 1'b1;
      push(cyc + 1, 2'b11, "R6 reset in halt");
      step(1); sys_reset_req = 1'b0; clear_irq();
      step(2);

      // R6 in deep standby
      osc_wait = 16'd5;
      pulse_stop(); step(2);
      sys_reset_req = 1'b1;
      push(cyc + 1, 2'b11, "R6 reset in stop");
      step(1); sys_reset_req = 1'b0;
      step(2);

      // R6 during the stabilization wait
      osc_wait = 16'd10; irq_req = 8'h01; irq_mask = 8'hFE;
      pulse_stop(); step(2);
      sys_reset_req = 1'b1;
      push(cyc + 1, 2'b11, "R6 reset in settle");
      step(1); sys_reset_req = 1'b0; clear_irq();
      step(2);

      // R6: reset request while running has no effect
      sys_reset_req = 1'b1;
      step(1); sys_reset_req = 1'b0;
      step(3);
      chk("R6 no effect while running", int'(cpu_clk_en), 1);

      step(5);
      chk("R10 all expected wakes seen", exp_cyc.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule